// File: doc/BRIEF.md
# Bidirectional Product-Term Steering Chain

This block sits between the AND-array of an eighteen-cell logic group and the cells' storage elements. Each cell comes with five direct product terms. A cell either absorbs terms or lends them. When it absorbs, it ORs its own terms with any partial sums that neighbouring cells push toward it. When it lends, it forwards all of its own terms, plus whatever reached it from the far side, to the next cell up or down. Chaining lenders lets one cell collect every term in the group.

The network is purely combinational. For every cell it returns the final sum, the logic span of that sum, and an error flag. The span is the number of steering hops the farthest borrowed term passes through, and a timing checker uses it to charge one allocator delay per hop. The error flag marks a configuration in which a partial sum has no valid destination. Examples are two cells claiming each other's terms, a sum pushed off either end of the chain, a sum sent into a cell that cannot take it, and a path longer than the allowed span.

Top module: `pterm_steer`

## Requirements
- R1: The route code of cell c is `route_i[2c+1:2c]`: 00 = sink (keep own terms and absorb arrivals), 01 = lend toward cell c+1, 10 = lend toward cell c-1, 11 = idle. The terms of cell c are `pterm_i[5c+4:5c]`. A sink cell with no lenders next to it outputs the OR of its own five terms.
- R2: A sink cell's sum also includes the terms of every cell in the unbroken run of 01 cells directly below it and in the unbroken run of 10 cells directly above it.
- R3: A cell whose route code is not sink drives a sum of 0 and a span of 0.
- R4: A sink cell's span is the longer of those two runs, so it is 0 for direct terms only and 1 when the nearest neighbours lend. The reported value saturates at 15.
- R5: When cells 0..8 lend upward and cells 10..17 lend downward, cell 9 responds to any single one of the 90 terms and reports span 9.
- R6: Cell 17 coded 01 or cell 0 coded 10 raises that cell's error flag.
- R7: A cell that receives a sum from below while coded 10 or 11, or receives one from above while coded 01 or 11, raises its error flag. This covers two neighbours claiming each other's terms.
- R8: A sink cell whose span exceeds MAX_SPAN (default 9) raises its error flag.
- R9: All outputs follow the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pterm_i | input | NCELL*NTERM | Direct product terms, five per cell |
| route_i | input | 2*NCELL | Per-cell route code |
| sum_o | output | NCELL | Final sum per cell |
| span_o | output | NCELL*SPAN_W | Logic span per cell, 4 bits each |
| cfg_err_o | output | NCELL | Per-cell configuration error |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the ports. The bench drives new terms and routes just after a falling edge and samples one nanosecond later, before the next edge. One check changes the inputs with no edge at all. An exhaustive sweep of every route combination over a four-cell copy is compared against a model that searches outward from each sink, and directed and random cases cover the full eighteen-cell group.

// File: rtl/pterm_steer.sv
module pterm_steer #(
  parameter int NCELL    = 18,
  parameter int NTERM    = 5,
  parameter int SPAN_W   = 4,
  parameter int MAX_SPAN = 9
) (
  input  logic [NCELL*NTERM-1:0]  pterm_i,
  input  logic [2*NCELL-1:0]      route_i,
  output logic [NCELL-1:0]        sum_o,
  output logic [NCELL*SPAN_W-1:0] span_o,
  output logic [NCELL-1:0]        cfg_err_o
);
  localparam int CNT_W = $clog2(NCELL + 1);
  localparam int W     = (CNT_W > SPAN_W) ? CNT_W : SPAN_W;
  localparam logic [W-1:0] CAP  = W'((1 << SPAN_W) - 1);
  localparam logic [W-1:0] LIMS = W'(MAX_SPAN);

  logic [NCELL-1:0] own, sink, lend_up, lend_dn, idle;
  logic [NCELL-1:0] lo_ps, hi_ps, lo_in, hi_in;
  logic [W-1:0]     lo_run [NCELL];
  logic [W-1:0]     hi_run [NCELL];

  for (genvar c = 0; c < NCELL; c++) begin : g_dec
    assign own[c]     = |pterm_i[c*NTERM +: NTERM];
    assign sink[c]    = route_i[2*c +: 2] == 2'b00;
    assign lend_up[c] = route_i[2*c +: 2] == 2'b01;
    assign lend_dn[c] = route_i[2*c +: 2] == 2'b10;
    assign idle[c]    = route_i[2*c +: 2] == 2'b11;
  end

  always_comb begin
    lo_ps[0]  = 1'b0;
    lo_in[0]  = 1'b0;
    lo_run[0] = '0;
    for (int c = 1; c < NCELL; c++) begin
      lo_in[c]  = lend_up[c-1];
      lo_ps[c]  = lend_up[c-1] & (own[c-1] | lo_ps[c-1]);
      lo_run[c] = lend_up[c-1] ? lo_run[c-1] + 1'b1 : '0;
    end
  end

  always_comb begin
    hi_ps[NCELL-1]  = 1'b0;
    hi_in[NCELL-1]  = 1'b0;
    hi_run[NCELL-1] = '0;
    for (int c = NCELL - 2; c >= 0; c--) begin
      hi_in[c]  = lend_dn[c+1];
      hi_ps[c]  = lend_dn[c+1] & (own[c+1] | hi_ps[c+1]);
      hi_run[c] = lend_dn[c+1] ? hi_run[c+1] + 1'b1 : '0;
    end
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic [W-1:0] reach, shown;
    logic         edge_err, flow_err;
    assign reach = !sink[c] ? '0 : (lo_run[c] > hi_run[c]) ? lo_run[c] : hi_run[c];
    assign shown = (reach > CAP) ? CAP : reach;
    assign sum_o[c] = sink[c] & (own[c] | lo_ps[c] | hi_ps[c]);
    assign span_o[c*SPAN_W +: SPAN_W] = shown[SPAN_W-1:0];
    assign edge_err = (c == NCELL - 1 && lend_up[c]) || (c == 0 && lend_dn[c]);
    assign flow_err = (lo_in[c] & (lend_dn[c] | idle[c])) |
                      (hi_in[c] & (lend_up[c] | idle[c]));
    assign cfg_err_o[c] = edge_err | flow_err | (reach > LIMS);
  end
endmodule

// File: rtl/pterm_steer_chk.sv
module pterm_steer_chk #(
  parameter int NCELL    = 18,
  parameter int NTERM    = 5,
  parameter int SPAN_W   = 4,
  parameter int MAX_SPAN = 9
) (
  input logic [NCELL*NTERM-1:0]  pterm_i,
  input logic [2*NCELL-1:0]      route_i,
  input logic [NCELL-1:0]        sum_o,
  input logic [NCELL*SPAN_W-1:0] span_o,
  input logic [NCELL-1:0]        cfg_err_o
);
  for (genvar c = 0; c < NCELL; c++) begin : g_chk
    always_comb begin
      // R3
      idle_sum_chk: assert (route_i[2*c +: 2] == 2'b00 || (!sum_o[c] && span_o[c*SPAN_W +: SPAN_W] == '0))
        else $error("non-sink cell %0d drives a sum or span", c);
      // R1
      own_term_chk: assert (!(route_i[2*c +: 2] == 2'b00 && |pterm_i[c*NTERM +: NTERM]) || sum_o[c])
        else $error("sink cell %0d lost its own terms", c);
      // R8
      span_limit_chk: assert (cfg_err_o[c] || 32'(span_o[c*SPAN_W +: SPAN_W]) <= MAX_SPAN)
        else $error("cell %0d span above limit without error", c);
      // R6
      chain_end_chk: assert (!((c == NCELL - 1 && route_i[2*c +: 2] == 2'b01) ||
                               (c == 0 && route_i[2*c +: 2] == 2'b10)) || cfg_err_o[c])
        else $error("cell %0d sends off the chain end without error", c);
    end
  end
endmodule

bind pterm_steer pterm_steer_chk #(
  .NCELL(NCELL), .NTERM(NTERM), .SPAN_W(SPAN_W), .MAX_SPAN(MAX_SPAN)
) u_chk (
  .pterm_i(pterm_i), .route_i(route_i), .sum_o(sum_o),
  .span_o(span_o), .cfg_err_o(cfg_err_o)
);

// File: tb/pterm_steer_test.sv
`timescale 1ns/1ps
module pterm_steer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int tests = 0, fails = 0;

  logic [89:0] pt_l;  logic [35:0] rt_l;
  logic [17:0] sum_l, err_l; logic [71:0] span_l;
  logic [19:0] pt_s;  logic [7:0]  rt_s;
  logic [3:0]  sum_s, err_s; logic [15:0] span_s;

  pterm_steer uut (.pterm_i(pt_l), .route_i(rt_l), .sum_o(sum_l), .span_o(span_l), .cfg_err_o(err_l));
  pterm_steer #(.NCELL(4), .NTERM(5), .SPAN_W(4), .MAX_SPAN(2)) uut_small
    (.pterm_i(pt_s), .route_i(rt_s), .sum_o(sum_s), .span_o(span_s), .cfg_err_o(err_s));

  logic [1:0] m [18];
  logic [4:0] p [18];
  logic [17:0] esum, eerr;
  logic [71:0] espan;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input int n, input int maxs);
    esum = '0; eerr = '0; espan = '0;
    for (int c = 0; c < n; c++) begin
      if (m[c] == 2'b00) begin
        logic acc; int r1, r2, sp, k;
        acc = |p[c]; r1 = 0; r2 = 0;
        k = c - 1;
        while (k >= 0 && m[k] == 2'b01) begin acc |= |p[k]; r1++; k--; end
        k = c + 1;
        while (k < n && m[k] == 2'b10) begin acc |= |p[k]; r2++; k++; end
        sp = (r1 > r2) ? r1 : r2;
        esum[c] = acc;
        espan[c*4 +: 4] = (sp > 15) ? 4'd15 : 4'(sp);
        if (sp > maxs) eerr[c] = 1'b1;
      end
      if (m[c] == 2'b01 && c == n - 1) eerr[c] = 1'b1;
      if (m[c] == 2'b10 && c == 0) eerr[c] = 1'b1;
      if (c > 0 && m[c-1] == 2'b01 && (m[c] == 2'b10 || m[c] == 2'b11)) eerr[c] = 1'b1;
      if (c < n - 1 && m[c+1] == 2'b10 && (m[c] == 2'b01 || m[c] == 2'b11)) eerr[c] = 1'b1;
    end
  endfunction

  task automatic run_big(input string tag);
    @(negedge clk);
    for (int c = 0; c < 18; c++) begin pt_l[c*5 +: 5] = p[c]; rt_l[c*2 +: 2] = m[c]; end
    model(18, 9);
    #1;
    chk({tag, " sum"}, 72'(sum_l), 72'(esum));
    chk({tag, " span"}, span_l, espan);
    chk({tag, " err"}, 72'(err_l), 72'(eerr));
  endtask

  task automatic run_small;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin pt_s[c*5 +: 5] = p[c]; rt_s[c*2 +: 2] = m[c]; end
    model(4, 2);
    #1;
    chk("R2 small sum", 72'(sum_s), 72'(esum[3:0]));
    chk("R4 small span", 72'(span_s), 72'(espan[15:0]));
    chk("R7 R8 small err", 72'(err_s), 72'(eerr[3:0]));
  endtask

  task automatic clear;
    for (int c = 0; c < 18; c++) begin m[c] = 2'b00; p[c] = 5'd0; end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    pt_l = '0; rt_l = '0; pt_s = '0; rt_s = '0;
    clear();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // R3 R1 idle state: all sinks, no terms
    chk("R1 rest sum", 72'(sum_l), 72'd0);
    chk("R4 rest span", span_l, 72'd0);
    chk("R7 rest err", 72'(err_l), 72'd0);

    // R1 each single term on a stand-alone sink
    for (int c = 0; c < 18; c++) begin
      clear(); p[c] = 5'b1 << (c % 5);
      run_big("R1 direct");
    end

    // R5 full gather into cell 9, each of the 90 terms alone
    for (int t = 0; t < 90; t++) begin
      clear();
      for (int c = 0; c < 9; c++) m[c] = 2'b01;
      for (int c = 10; c < 18; c++) m[c] = 2'b10;
      p[t/5] = 5'b1 << (t % 5);
      run_big("R5 gather");
    end
    chk("R5 span cell9", 72'(span_l[36 +: 4]), 72'd9);

    // R8 run of ten below a sink
    clear();
    for (int c = 0; c < 10; c++) m[c] = 2'b01;
    run_big("R8 overlong");
    chk("R8 cell10 err", 72'(err_l[10]), 72'd1);

    // R6 chain ends
    clear(); m[17] = 2'b01; m[0] = 2'b10;
    run_big("R6 ends");
    chk("R6 end flags", 72'({err_l[17], err_l[0]}), 72'd3);

    // R7 head-on claim
    clear(); m[4] = 2'b01; m[5] = 2'b10; p[4] = 5'h1f; p[5] = 5'h1f;
    run_big("R7 headon");
    chk("R3 headon sums", 72'({sum_l[5], sum_l[4]}), 72'd0);

    // R9 no clock edge needed
    clear(); run_big("R9 base");
    #1 pt_l[3*5] = 1'b1; #1;
    chk("R9 comb follow", 72'(sum_l[3]), 72'd1);

    // R2 R4 random configs on the full group
    for (int i = 0; i < 300; i++) begin
      for (int c = 0; c < 18; c++) begin
        m[c] = 2'($urandom_range(0, 3));
        p[c] = ($urandom_range(0, 3) == 0) ? 5'(1 << $urandom_range(0, 4)) : 5'd0;
      end
      run_big("R2 R4 random");
    end

    // R2 R4 R7 R8 exhaustive routes on four cells
    for (int mc = 0; mc < 256; mc++) begin
      for (int pat = 0; pat < 3; pat++) begin
        clear();
        for (int c = 0; c < 4; c++) m[c] = 2'(mc >> (2*c));
        if (pat == 0) for (int c = 0; c < 4; c++) p[c] = 5'h1f;
        if (pat == 1) p[mc % 4] = 5'b1 << (mc % 5);
        run_small();
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule